// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns 32-bit words into a serial bit stream organised in frames. Software, or a neighbouring block, writes a word into a one-word data register. At each word boundary the transmitter moves that word into its shift register and clocks out the chosen number of low-order bits, one per bit-clock tick. Ticks arrive as a one-cycle enable, `bit_tick`, in the system clock domain.

A frame holds one or two phases. Each phase has its own word width and word count. A programmable delay of zero to two bit periods sits between the frame-sync tick and the first data bit. Frame sync can be produced locally, at the moment the data register is copied into the shift register. It can also be taken from an input fed by an outside source or by a frame-sync generator. The transmitter reports three flags: the data register is free, the shift register ran dry, and a frame sync arrived inside a frame.

Top module: `fs_serial_tx`

## Requirements
- R1: The word width code selects how many low bits of the word are sent: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32. The upper bits are never sent.
- R2: With `cfg_lsb_first` = 0, bit W-1 of the word goes out first and bit 0 last. With `cfg_lsb_first` = 1 the order is reversed.
- R3: Counting the frame-sync tick as tick 0, the first data bit appears at tick `cfg_delay`. Codes 0, 1 and 2 give that many ticks and code 3 behaves as 2. `sd_out` is low during the delay ticks.
- R4: With `cfg_fs_ext` = 0, a frame starts on the first tick at which the data register holds an unsent word. `fs_out` is high for exactly that one bit period. `fs_in` has no effect in this mode.
- R5: With `cfg_fs_ext` = 1, a frame starts on a tick at which `fs_in` is high, and `fs_out` stays low. If no word is waiting, the first word slot is sent as zeros.
- R6: A frame carries `cfg_flen1`+1 words of width `cfg_wlen1`. When `cfg_dual` = 1, it then carries `cfg_flen2`+1 words of width `cfg_wlen2`. The words follow one another with no idle bit between them.
- R7: `rdy` is 1 after reset. A write clears it. The copy into the shift register sets it again.
- R8: `empty` is 1 after reset and is cleared by a copy. It is set when a word slot begins with no unsent word. That slot is then sent as zeros, and the previous word is not repeated.
- R9: With `cfg_fig` = 1, a frame sync seen on `fs_in` during an active frame is disregarded. It does not set `sync_err` and does not change the bit stream.
- R10: With `cfg_fig` = 0 in external mode, `fs_in` high on a tick inside an active frame sets `sync_err`. The final tick of the frame is excluded, because a sync there starts the next frame. The flag stays set, and the frame in progress continues unchanged.
- R11: While `tx_en` is 0 the transmitter is idle. `sd_out`, `fs_out` and `sync_err` are 0, `empty` is 1, and no copy takes place. Writes still load the data register.
- R12: `sd_out` is low when the transmitter is idle, including between frames. The serial outputs change only on ticks, or when the transmitter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; 0 holds it idle |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 32 | Word to load into the data register |
| bit_tick | input | 1 | One-cycle bit-clock enable |
| fs_in | input | 1 | External or generated frame sync, sampled on ticks |
| cfg_wlen1 | input | 3 | Word width code, phase 1 |
| cfg_wlen2 | input | 3 | Word width code, phase 2 |
| cfg_flen1 | input | FLEN_W | Words in phase 1, minus one |
| cfg_flen2 | input | FLEN_W | Words in phase 2, minus one |
| cfg_dual | input | 1 | Enable a second phase |
| cfg_delay | input | DLY_W | Data delay in bit periods |
| cfg_lsb_first | input | 1 | Send bit 0 first |
| cfg_fs_ext | input | 1 | 0: sync on copy, 1: follow fs_in |
| cfg_fig | input | 1 | Ignore frame syncs inside a frame |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync produced on copy |
| rdy | output | 1 | Data register free |
| empty | output | 1 | Shift register ran dry |
| sync_err | output | 1 | Unexpected frame sync seen |

## Verification
The bench builds the block with its defaults: a 7-bit word-count field and a maximum delay of 2. With these values every width code up to the full 32 bits can be paired with all three delay settings, and both bit orders can be exercised in single-word frames. The same build also covers a dual-phase frame whose phases differ in width and word count, and an underrun in the second slot of a two-word frame. In external-sync mode the bench places a sync on the frame's final tick, inside the frame with the ignore option set, and inside the frame with the option clear.

// File: rtl/sptx_pkg.sv
package sptx_pkg;

   localparam int WORD_W = 32;
   localparam int BCNT_W = 5;
   localparam int WLEN_W = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_SHIFT = 2'd2
   } sptx_state_e;

   // width in bits for a 3-bit width code
   function automatic logic [WLEN_W-1:0] wlen_bits(input logic [2:0] code);
      logic [WLEN_W-1:0] w;
      case (code)
         3'd0:    w = 6'd8;
         3'd1:    w = 6'd12;
         3'd2:    w = 6'd16;
         3'd3:    w = 6'd20;
         3'd4:    w = 6'd24;
         default: w = 6'd32;
      endcase
      return w;
   endfunction

   // bit counter preset: width minus one
   function automatic logic [BCNT_W-1:0] last_bit(input logic [2:0] code);
      logic [WLEN_W-1:0] w;
      w = wlen_bits(code) - 6'd1;
      return w[BCNT_W-1:0];
   endfunction

endpackage

// File: rtl/sptx_holdreg.sv
module sptx_holdreg
   import sptx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   output logic [WORD_W-1:0] hold_q,
   output logic              rdy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         rdy    <= 1'b1;
      end else if (wr_en) begin
         hold_q <= wr_data;
         rdy    <= 1'b0;
      end else if (take) begin
         rdy    <= 1'b1;
      end
   end

endmodule

// File: rtl/sptx_shifter.sv
module sptx_shifter
   import sptx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              load,
   input  logic              emit,
   input  logic [WORD_W-1:0] load_word,
   input  logic [2:0]        load_code,
   input  logic              lsb_first,
   output logic              sd_out
);

   logic [WORD_W-1:0] sreg;
   logic [WORD_W-1:0] aligned;
   logic [WORD_W-1:0] src;
   logic [WLEN_W-1:0] pad;

   // MSB-first words are moved to the top so the first bit is always at bit 31
   always_comb begin
      pad     = 6'd32 - wlen_bits(load_code);
      aligned = lsb_first ? load_word : (load_word << pad);
      src     = load ? aligned : sreg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         sd_out <= 1'b0;
      end else if (!en) begin
         sd_out <= 1'b0;
      end else if (tick) begin
         if (emit) begin
            sd_out <= lsb_first ? src[0] : src[WORD_W-1];
            sreg   <= lsb_first ? (src >> 1) : (src << 1);
         end else begin
            sd_out <= 1'b0;
            if (load) sreg <= aligned;
         end
      end
   end

endmodule

// File: rtl/sptx_framer.sv
module sptx_framer
   import sptx_pkg::*;
#(
   parameter int FLEN_W  = 7,
   parameter int MAX_DLY = 2,
   localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rdy,
   input  logic              fs_in,
   input  logic [2:0]        cfg_wlen1,
   input  logic [2:0]        cfg_wlen2,
   input  logic [FLEN_W-1:0] cfg_flen1,
   input  logic [FLEN_W-1:0] cfg_flen2,
   input  logic              cfg_dual,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic              cfg_fs_ext,
   input  logic              cfg_fig,
   output logic              load,
   output logic              emit,
   output logic              take,
   output logic [2:0]        load_code,
   output logic              fs_out,
   output logic              empty,
   output logic              sync_err
);

   sptx_state_e       st;
   logic [BCNT_W-1:0] bcnt;
   logic [FLEN_W-1:0] wcnt;
   logic [DLY_W-1:0]  dcnt;
   logic              phase;

   logic [FLEN_W-1:0] cur_flen;
   logic [DLY_W-1:0]  dly_eff;
   logic              act, last_word, boundary, frame_end, trig, start;
   logic              next_word, nxt_phase, in_frame;

   always_comb begin
      act       = tick && en;
      cur_flen  = phase ? cfg_flen2 : cfg_flen1;
      dly_eff   = (cfg_delay > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : cfg_delay;
      last_word = (wcnt == cur_flen) && (!cfg_dual || phase);
      boundary  = (st == ST_SHIFT) && (bcnt == '0);
      frame_end = boundary && last_word;
      next_word = boundary && !last_word;
      nxt_phase = (wcnt == cur_flen) ? 1'b1 : phase;
      trig      = cfg_fs_ext ? fs_in : !rdy;
      start     = ((st == ST_IDLE) || frame_end) && trig;
      in_frame  = (st != ST_IDLE) && !frame_end;
      load      = act && (start || next_word);
      load_code = (start || !nxt_phase) ? cfg_wlen1 : cfg_wlen2;
      emit      = act && ((start && dly_eff == '0)
                       || (!start && st == ST_DELAY && dcnt == '0)
                       || (st == ST_SHIFT && bcnt != '0)
                       || next_word);
      take      = load && !rdy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bcnt     <= '0;
         wcnt     <= '0;
         dcnt     <= '0;
         phase    <= 1'b0;
         fs_out   <= 1'b0;
         empty    <= 1'b1;
         sync_err <= 1'b0;
      end else if (!en) begin
         st       <= ST_IDLE;
         fs_out   <= 1'b0;
         empty    <= 1'b1;
         sync_err <= 1'b0;
      end else if (tick) begin
         fs_out <= start && !cfg_fs_ext;
         if (cfg_fs_ext && fs_in && in_frame && !cfg_fig) sync_err <= 1'b1;
         if (load) empty <= rdy;
         if (start) begin
            phase <= 1'b0;
            wcnt  <= '0;
            if (dly_eff == '0) begin
               st   <= ST_SHIFT;
               bcnt <= last_bit(cfg_wlen1);
            end else begin
               st   <= ST_DELAY;
               dcnt <= dly_eff - DLY_W'(1);
            end
         end else begin
            case (st)
               ST_DELAY: begin
                  if (dcnt == '0) begin
                     st   <= ST_SHIFT;
                     bcnt <= last_bit(cfg_wlen1);
                  end else begin
                     dcnt <= dcnt - DLY_W'(1);
                  end
               end
               ST_SHIFT: begin
                  if (bcnt != '0) begin
                     bcnt <= bcnt - BCNT_W'(1);
                  end else if (!last_word) begin
                     phase <= nxt_phase;
                     wcnt  <= (wcnt == cur_flen) ? '0 : FLEN_W'(wcnt + 1'b1);
                     bcnt  <= last_bit(load_code);
                  end else begin
                     st <= ST_IDLE;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/fs_serial_tx.sv
module fs_serial_tx
   import sptx_pkg::*;
#(
   parameter int FLEN_W  = 7,
   parameter int MAX_DLY = 2,
   localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic              bit_tick,
   input  logic              fs_in,
   input  logic [2:0]        cfg_wlen1,
   input  logic [2:0]        cfg_wlen2,
   input  logic [FLEN_W-1:0] cfg_flen1,
   input  logic [FLEN_W-1:0] cfg_flen2,
   input  logic              cfg_dual,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic              cfg_lsb_first,
   input  logic              cfg_fs_ext,
   input  logic              cfg_fig,
   output logic              sd_out,
   output logic              fs_out,
   output logic              rdy,
   output logic              empty,
   output logic              sync_err
);

   generate
      if (FLEN_W < 1 || FLEN_W > 12) begin : g_bad_flen
         $error("fs_serial_tx: FLEN_W must lie in 1..12");
      end
      if (MAX_DLY < 1 || MAX_DLY > 3) begin : g_bad_dly
         $error("fs_serial_tx: MAX_DLY must lie in 1..3");
      end
   endgenerate

   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] load_word;
   logic              load, emit, take;
   logic [2:0]        load_code;

   assign load_word = rdy ? '0 : hold_q;

   sptx_holdreg u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .hold_q  (hold_q),
      .rdy     (rdy)
   );

   sptx_framer #(.FLEN_W(FLEN_W), .MAX_DLY(MAX_DLY)) u_frm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (tx_en),
      .tick       (bit_tick),
      .rdy        (rdy),
      .fs_in      (fs_in),
      .cfg_wlen1  (cfg_wlen1),
      .cfg_wlen2  (cfg_wlen2),
      .cfg_flen1  (cfg_flen1),
      .cfg_flen2  (cfg_flen2),
      .cfg_dual   (cfg_dual),
      .cfg_delay  (cfg_delay),
      .cfg_fs_ext (cfg_fs_ext),
      .cfg_fig    (cfg_fig),
      .load       (load),
      .emit       (emit),
      .take       (take),
      .load_code  (load_code),
      .fs_out     (fs_out),
      .empty      (empty),
      .sync_err   (sync_err)
   );

   sptx_shifter u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (tx_en),
      .tick      (bit_tick),
      .load      (load),
      .emit      (emit),
      .load_word (load_word),
      .load_code (load_code),
      .lsb_first (cfg_lsb_first),
      .sd_out    (sd_out)
   );

endmodule

// File: rtl/fs_serial_tx_chk.sv
module fs_serial_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic bit_tick,
   input logic wr_en,
   input logic cfg_fs_ext,
   input logic cfg_fig,
   input logic sd_out,
   input logic fs_out,
   input logic rdy,
   input logic empty,
   input logic sync_err
);

   a_r11_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!sd_out && !fs_out && !sync_err && empty));

   a_r12_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && tx_en) |=> ($stable(sd_out) && $stable(fs_out)));

   a_r4_fs_on_copy: assert property (@(posedge clk) disable iff (!rst_n)
      fs_out |-> !empty);

   a_r5_ext_no_fs_out: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fs_ext && bit_tick && tx_en) |=> !fs_out);

   a_r7_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rdy);

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err && tx_en) |=> sync_err);

   a_r9_ignore_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && tx_en && cfg_fig && !sync_err) |=> !sync_err);

endmodule

bind fs_serial_tx fs_serial_tx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_en      (tx_en),
   .bit_tick   (bit_tick),
   .wr_en      (wr_en),
   .cfg_fs_ext (cfg_fs_ext),
   .cfg_fig    (cfg_fig),
   .sd_out     (sd_out),
   .fs_out     (fs_out),
   .rdy        (rdy),
   .empty      (empty),
   .sync_err   (sync_err)
);

// File: tb/tb_fs_serial_tx.sv
module tb_fs_serial_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        bit_tick = 1'b0;
   logic        fs_in = 1'b0;
   logic [2:0]  cfg_wlen1 = '0;
   logic [2:0]  cfg_wlen2 = '0;
   logic [6:0]  cfg_flen1 = '0;
   logic [6:0]  cfg_flen2 = '0;
   logic        cfg_dual = 1'b0;
   logic [1:0]  cfg_delay = '0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_fs_ext = 1'b0;
   logic        cfg_fig = 1'b0;
   logic        sd_out, fs_out, rdy, empty, sync_err;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   fs_serial_tx dut (.*);

   // {width code, lsb first, delay, data}
   localparam logic [37:0] VEC [6] = '{
      {3'd0, 1'b0, 2'd0, 32'hFFFF_FFA5},
      {3'd1, 1'b1, 2'd1, 32'h0000_0ABC},
      {3'd2, 1'b0, 2'd2, 32'h1234_8001},
      {3'd3, 1'b1, 2'd0, 32'h000F_00F1},
      {3'd4, 1'b0, 2'd1, 32'h00C3_5A7E},
      {3'd5, 1'b1, 2'd3, 32'h8000_0001}
   };

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   function automatic int tb_w(input logic [2:0] c);
      return (c > 3'd4) ? 32 : 8 + 4 * int'(c);
   endfunction

   function automatic logic tb_bit(input logic [31:0] d, input logic [2:0] c,
                                   input logic lsb, input int i);
      return lsb ? d[i] : d[tb_w(c) - 1 - i];
   endfunction

   task automatic run_tests();
      int bad;
      int fsn;
      logic e;
      // reset state, R7 R8 R10 R12
      chk(sd_out == 1'b0, "R12 reset sd", longint'(sd_out), 0);
      chk(fs_out == 1'b0, "R12 reset fs", longint'(fs_out), 0);
      chk(rdy == 1'b1, "R7 reset rdy", longint'(rdy), 1);
      chk(empty == 1'b1, "R8 reset empty", longint'(empty), 1);
      chk(sync_err == 1'b0, "R10 reset sync_err", longint'(sync_err), 0);

      // table: R1 R2 R3 R4 R7 R12
      for (int v = 0; v < 6; v++) begin
         int d;
         int w;
         cfg_wlen1 = VEC[v][37:35];
         cfg_lsb_first = VEC[v][34];
         cfg_delay = VEC[v][33:32];
         d = (VEC[v][33:32] == 2'd3) ? 2 : int'(VEC[v][33:32]);
         w = tb_w(VEC[v][37:35]);
         wr(VEC[v][31:0]);
         chk(rdy == 1'b0, "R7 write clears rdy", longint'(rdy), 0);
         bad = 0; fsn = 0;
         for (int k = 0; k < d + w; k++) begin
            tick();
            if (k == 0) begin
               chk(fs_out == 1'b1, "R4 fs on copy tick", longint'(fs_out), 1);
               chk(rdy == 1'b1, "R7 copy sets rdy", longint'(rdy), 1);
            end else if (fs_out) fsn++;
            e = (k < d) ? 1'b0 : tb_bit(VEC[v][31:0], VEC[v][37:35], VEC[v][34], k - d);
            if (sd_out !== e) bad++;
         end
         chk(bad == 0, "R1 R2 R3 bit stream", bad, 0);
         chk(fsn == 0, "R4 fs one bit period", fsn, 0);
         tick();
         chk(sd_out == 1'b0 && fs_out == 1'b0, "R12 idle after frame", longint'(sd_out), 0);
      end

      // R6 dual phase: 1 x 8 bits then 2 x 12 bits, delay 1
      cfg_dual = 1'b1; cfg_wlen1 = 3'd0; cfg_flen1 = 7'd0;
      cfg_wlen2 = 3'd1; cfg_flen2 = 7'd1; cfg_delay = 2'd1; cfg_lsb_first = 1'b0;
      wr(32'h0000_0096);
      bad = 0; fsn = 0;
      for (int k = 0; k < 33; k++) begin
         int j;
         tick();
         if (fs_out) fsn++;
         if (k == 0) wr(32'h0000_0A5C);
         if (k == 9) wr(32'h0000_03E1);
         j = k - 1;
         if (k < 1) e = 1'b0;
         else if (j < 8) e = tb_bit(32'h96, 3'd0, 1'b0, j);
         else if (j < 20) e = tb_bit(32'hA5C, 3'd1, 1'b0, j - 8);
         else e = tb_bit(32'h3E1, 3'd1, 1'b0, j - 20);
         if (sd_out !== e) bad++;
      end
      chk(bad == 0, "R6 dual phase stream", bad, 0);
      chk(fsn == 1, "R6 one sync per frame", fsn, 1);
      chk(empty == 1'b0, "R8 no empty slot", longint'(empty), 0);
      tick();
      chk(sd_out == 1'b0, "R12 idle after dual frame", longint'(sd_out), 0);
      cfg_dual = 1'b0; cfg_delay = 2'd0;

      // R8 underrun in second slot of a two-word frame
      cfg_flen1 = 7'd1;
      wr(32'h0000_005B);
      bad = 0;
      for (int k = 0; k < 16; k++) begin
         tick();
         if (k == 0) chk(empty == 1'b0, "R8 copy clears empty", longint'(empty), 0);
         if (k == 8) chk(empty == 1'b1 && rdy == 1'b1, "R8 empty on dry slot", longint'(empty), 1);
         e = (k < 8) ? tb_bit(32'h5B, 3'd0, 1'b0, k) : 1'b0;
         if (sd_out !== e) bad++;
      end
      chk(bad == 0, "R8 dry slot sent as zeros", bad, 0);
      tick();
      cfg_flen1 = 7'd0;

      // R4 fs_in has no effect in copy mode
      fs_in = 1'b1; tick(); fs_in = 1'b0;
      chk(fs_out == 1'b0 && sd_out == 1'b0, "R4 fs_in ignored", longint'(fs_out), 0);

      // R11 disabled: no copy, outputs quiet
      tx_en = 1'b0;
      wr(32'h0000_00F0);
      tick(); tick(); tick();
      chk(rdy == 1'b0, "R11 no copy while disabled", longint'(rdy), 0);
      chk(sd_out == 1'b0 && fs_out == 1'b0, "R11 outputs low", longint'(fs_out), 0);
      tx_en = 1'b1;
      tick();
      chk(fs_out == 1'b1 && sd_out == 1'b1, "R11 starts after enable", longint'(fs_out), 1);
      for (int k = 0; k < 8; k++) tick();

      // R5 R9 external sync with ignore set
      cfg_fs_ext = 1'b1; cfg_fig = 1'b1;
      wr(32'h0000_00C3);
      tick(); tick();
      chk(rdy == 1'b0 && sd_out == 1'b0, "R5 waits for fs_in", longint'(rdy), 0);
      bad = 0; fsn = 0;
      for (int k = 0; k < 8; k++) begin
         fs_in = (k == 0 || k == 3);
         tick();
         fs_in = 1'b0;
         if (fs_out) fsn++;
         if (sd_out !== tb_bit(32'hC3, 3'd0, 1'b0, k)) bad++;
      end
      chk(fsn == 0, "R5 fs_out stays low", fsn, 0);
      chk(bad == 0, "R9 stream undisturbed", bad, 0);
      chk(sync_err == 1'b0, "R9 no sync error", longint'(sync_err), 0);
      tick();
      // R5 start without data
      fs_in = 1'b1; tick(); fs_in = 1'b0;
      chk(empty == 1'b1 && sd_out == 1'b0, "R5 zero slot when no word", longint'(empty), 1);
      for (int k = 1; k < 9; k++) tick();

      // R10 sync error window
      cfg_fig = 1'b0;
      wr(32'h0000_006D);
      bad = 0;
      for (int k = 0; k < 8; k++) begin
         fs_in = (k == 0);
         tick();
         fs_in = 1'b0;
         if (k == 0) wr(32'h0000_00A9);
         if (sd_out !== tb_bit(32'h6D, 3'd0, 1'b0, k)) bad++;
      end
      fs_in = 1'b1; tick(); fs_in = 1'b0;
      chk(sync_err == 1'b0, "R10 sync on final tick is no error", longint'(sync_err), 0);
      if (sd_out !== tb_bit(32'hA9, 3'd0, 1'b0, 0)) bad++;
      for (int k = 1; k < 8; k++) begin
         fs_in = (k == 4);
         tick();
         fs_in = 1'b0;
         if (k == 4) chk(sync_err == 1'b1, "R10 mid-frame sync flagged", longint'(sync_err), 1);
         if (sd_out !== tb_bit(32'hA9, 3'd0, 1'b0, k)) bad++;
      end
      chk(bad == 0, "R10 frame continues", bad, 0);
      tick();
      chk(sync_err == 1'b1, "R10 flag sticky", longint'(sync_err), 1);
      @(negedge clk) tx_en = 1'b0;
      @(negedge clk) tx_en = 1'b1;
      chk(sync_err == 1'b0 && empty == 1'b1, "R11 disable clears error", longint'(sync_err), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule